// File: doc/BRIEF.md
# Sleep Mode and Wake-Up Sequencer

This block moves a small processor core between normal execution and three sleep states. When the core raises a sleep request, a two-bit mode code picks the target state. In the light state (idle) the core clock is gated but the main oscillator keeps running. In the two deep states (power-down and power-save) the oscillator is stopped as well. The block watches a set of wake sources and decides when the core may run again. Those sources are an external reset, a watchdog reset, a low-level external interrupt (presented here as an active-high level) and the overflow and compare events of an asynchronously clocked timer.

A wake from a deep state does not take effect at once. The oscillator is turned back on first, and the core clock stays gated while a stabilisation counter runs. That counter is driven by a free-running slow tick, so it keeps counting while the main oscillator is off. If the level interrupt that caused the wake goes away before the counter expires, the wake is abandoned and the block goes back to sleep. Once the core runs again, the interrupt-flag update is held back by a number of instruction cycles that depends on the wake source. An interrupt-entry strobe follows that update only when the global interrupt enable is set.

Top module: `slp_ctrl`

## Requirements
- R1: After `rst`, the core clock enable and oscillator enable are 1, and `wake_pending`, `flag_upd`, `isr_go` and `core_rst` are 0.
- R2: A sleep request with mode 2'b00 enters idle (core clock enable 0, oscillator enable 1). Mode 2'b10 enters power-down and mode 2'b11 enters power-save (both enables 0). In each case the outputs change on the clock edge that samples the request.
- R3: A sleep request with the reserved mode 2'b01 is ignored, and the core clock enable stays 1.
- R4: In idle, a level interrupt or an individually enabled timer event returns the core to running on the next edge, with no stabilisation delay. A disabled timer event does not wake it.
- R5: In power-down, only the level interrupt, a watchdog reset with the watchdog enabled, or an external reset can end sleep. Timer events and a watchdog reset with the watchdog disabled leave the block asleep.
- R6: Power-save also accepts the timer overflow and compare events as wake sources. This holds only when the asynchronous timer clock select is 1 and the event's own enable is 1, and it does not depend on the global interrupt enable.
- R7: A deep-state wake sets the oscillator enable and `wake_pending` to 1 while the core clock stays gated. The core clock enable returns on the edge that samples the TOUT_TICKS-th `settle_tick` pulse, and not before.
- R8: If the wake source is the level interrupt and it drops during stabilisation, the block returns to the deep state it came from (oscillator enable 0, `wake_pending` 0). No flag update follows.
- R9: After a wake by the level interrupt, `flag_upd` pulses for one cycle on the edge of the 2nd `instr_tick` after wake. After a wake by a timer event, it pulses on the 3rd.
- R10: `isr_go` pulses together with `flag_upd` when `gie` is 1, and stays 0 when `gie` is 0.
- R11: An external reset in any state brings the core clock enable back to 1 on the next edge and cancels any pending flag update.
- R12: A wake caused by the watchdog produces a one-cycle `core_rst` pulse as the core clock returns, and produces no `flag_upd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst | input | 1 | External reset request (level) |
| wdt_rst | input | 1 | Watchdog reset event |
| wdt_en | input | 1 | Watchdog enabled |
| sleep_req | input | 1 | Sleep request strobe from the core |
| sleep_mode | input | 2 | Sleep state code: 00 idle, 01 reserved, 10 power-down, 11 power-save |
| lvl_irq | input | 1 | External level interrupt, active high |
| tmr_async | input | 1 | Timer runs from its asynchronous clock |
| tmr_ovf | input | 1 | Timer overflow event |
| tmr_ovf_ie | input | 1 | Overflow interrupt enable |
| tmr_cmp | input | 1 | Timer compare-match event |
| tmr_cmp_ie | input | 1 | Compare interrupt enable |
| gie | input | 1 | Global interrupt enable |
| settle_tick | input | 1 | Free-running slow tick for the stabilisation counter |
| instr_tick | input | 1 | One pulse per executed instruction cycle |
| core_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Main oscillator enable |
| wake_pending | output | 1 | Stabilisation in progress |
| flag_upd | output | 1 | Interrupt-flag update strobe |
| isr_go | output | 1 | Interrupt-entry strobe |
| core_rst | output | 1 | Core reset pulse after a watchdog wake |

## Verification
The assertions assume `rst` is applied before the first check. They also assume that any level interrupt meant to complete a wake stays high through the sampling edge of the last stabilisation tick. The stimulus changes inputs only on falling clock edges. It drops `lvl_irq` before the counter expires only in the cases meant to test cancellation, and it keeps `gie` constant across each flag-delay window. Timer events and watchdog resets are applied as single-cycle pulses, and the sweeps cover every sleep mode, every wake source, both asynchronous-select settings and both watchdog-enable settings.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_IDLE   = 2'd1,
        ST_DEEP   = 2'd2,
        ST_SETTLE = 2'd3
    } slp_state_e;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_RSVD  = 2'b01,
        MODE_PDOWN = 2'b10,
        MODE_PSAVE = 2'b11
    } slp_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LEVEL = 2'd1,
        SRC_TIMER = 2'd2,
        SRC_WDOG  = 2'd3
    } wake_src_e;

    typedef struct packed {
        logic lvl;
        logic ovf;
        logic ovf_ie;
        logic cmp;
        logic cmp_ie;
        logic async_clk;
        logic wdt_rst;
        logic wdt_en;
    } wake_in_s;

    function automatic logic timer_hit(input wake_in_s w);
        return (w.ovf && w.ovf_ie) || (w.cmp && w.cmp_ie);
    endfunction

    function automatic logic is_deep(input slp_mode_e m);
        return (m == MODE_PDOWN) || (m == MODE_PSAVE);
    endfunction

endpackage

// File: rtl/slp_wake_sel.sv
module slp_wake_sel
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slp_state_e st,
    input  slp_mode_e  mode,
    input  wake_in_s   win,
    output wake_src_e  src
);

    logic wdog_hit;
    logic tmr_ok_deep;

    assign wdog_hit    = win.wdt_rst && win.wdt_en;
    assign tmr_ok_deep = (mode == MODE_PSAVE) && win.async_clk && timer_hit(win);

    always_comb begin
        src = SRC_NONE;
        unique case (st)
            ST_IDLE: begin
                if (wdog_hit)            src = SRC_WDOG;
                else if (win.lvl)        src = SRC_LEVEL;
                else if (timer_hit(win)) src = SRC_TIMER;
            end
            ST_DEEP: begin
                if (wdog_hit)            src = SRC_WDOG;
                else if (win.lvl)        src = SRC_LEVEL;
                else if (tmr_ok_deep)    src = SRC_TIMER;
            end
            default: src = SRC_NONE;
        endcase
    end

    // R5: power-down never selects a timer wake
    assert_pd_no_timer_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DEEP && mode == MODE_PDOWN) |-> (src != SRC_TIMER));

endmodule

// File: rtl/slp_settle_timer.sv
module slp_settle_timer #(
    parameter int TOUT_TICKS = 16,
    localparam int CNT_W = $clog2(TOUT_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && tick && (cnt == LAST);

    // R7: the counter never passes the final tick count
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

endmodule

// File: rtl/slp_flag_delay.sv
module slp_flag_delay
    import slp_pkg::*;
#(
    parameter int EXT_LAT = 2,
    parameter int TMR_LAT = 3,
    localparam int LAT_W = $clog2((EXT_LAT > TMR_LAT ? EXT_LAT : TMR_LAT) + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      load,
    input  wake_src_e load_src,
    input  logic      active,
    input  logic      instr_tick,
    input  logic      gie,
    output logic      flag_upd,
    output logic      isr_go
);

    logic [LAT_W-1:0] cnt;
    logic [LAT_W-1:0] load_val;
    logic             fire;

    always_comb begin
        unique case (load_src)
            SRC_LEVEL: load_val = LAT_W'(EXT_LAT);
            SRC_TIMER: load_val = LAT_W'(TMR_LAT);
            default:   load_val = '0;
        endcase
    end

    assign fire = active && instr_tick && (cnt == LAT_W'(1)) && !clr && !load;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt      <= '0;
            flag_upd <= 1'b0;
            isr_go   <= 1'b0;
        end else begin
            flag_upd <= fire;
            isr_go   <= fire && gie;
            if (load) begin
                cnt <= load_val;
            end else if (active && instr_tick && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // R9: the flag update is a single-cycle strobe
    assert_flag_single_R9: assert property (@(posedge clk) disable iff (rst)
        flag_upd |=> !flag_upd);

    // R10: interrupt entry only accompanies a flag update
    assert_isr_gated_R10: assert property (@(posedge clk) disable iff (rst)
        isr_go |-> flag_upd);

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int TOUT_TICKS = 16,
    parameter int EXT_LAT    = 2,
    parameter int TMR_LAT    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_rst,
    input  logic       wdt_rst,
    input  logic       wdt_en,
    input  logic       sleep_req,
    input  logic [1:0] sleep_mode,
    input  logic       lvl_irq,
    input  logic       tmr_async,
    input  logic       tmr_ovf,
    input  logic       tmr_ovf_ie,
    input  logic       tmr_cmp,
    input  logic       tmr_cmp_ie,
    input  logic       gie,
    input  logic       settle_tick,
    input  logic       instr_tick,
    output logic       core_clk_en,
    output logic       osc_en,
    output logic       wake_pending,
    output logic       flag_upd,
    output logic       isr_go,
    output logic       core_rst
);

    slp_state_e st, st_n;
    slp_mode_e  mode_q, mode_n, req_mode;
    wake_src_e  src_q, src_n, wsrc, load_src;
    wake_in_s   win;
    logic       load, settle_done, core_rst_q, core_rst_n;

    assign req_mode = slp_mode_e'(sleep_mode);

    assign win = '{lvl: lvl_irq, ovf: tmr_ovf, ovf_ie: tmr_ovf_ie,
                   cmp: tmr_cmp, cmp_ie: tmr_cmp_ie, async_clk: tmr_async,
                   wdt_rst: wdt_rst, wdt_en: wdt_en};

    slp_wake_sel u_sel (
        .clk  (clk),
        .rst  (rst),
        .st   (st),
        .mode (mode_q),
        .win  (win),
        .src  (wsrc)
    );

    slp_settle_timer #(.TOUT_TICKS(TOUT_TICKS)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .run  (st == ST_SETTLE),
        .tick (settle_tick),
        .done (settle_done)
    );

    always_comb begin
        st_n       = st;
        mode_n     = mode_q;
        src_n      = src_q;
        load       = 1'b0;
        load_src   = SRC_NONE;
        core_rst_n = 1'b0;
        if (ext_rst) begin
            st_n  = ST_ACTIVE;
            src_n = SRC_NONE;
        end else begin
            unique case (st)
                ST_ACTIVE: begin
                    if (sleep_req) begin
                        if (req_mode == MODE_IDLE) begin
                            st_n   = ST_IDLE;
                            mode_n = MODE_IDLE;
                        end else if (is_deep(req_mode)) begin
                            st_n   = ST_DEEP;
                            mode_n = req_mode;
                        end
                    end
                end
                ST_IDLE: begin
                    if (wsrc == SRC_WDOG) begin
                        st_n       = ST_ACTIVE;
                        core_rst_n = 1'b1;
                    end else if (wsrc != SRC_NONE) begin
                        st_n     = ST_ACTIVE;
                        load     = 1'b1;
                        load_src = wsrc;
                    end
                end
                ST_DEEP: begin
                    if (wsrc != SRC_NONE) begin
                        st_n  = ST_SETTLE;
                        src_n = wsrc;
                    end
                end
                ST_SETTLE: begin
                    if (src_q == SRC_LEVEL && !lvl_irq) begin
                        st_n  = ST_DEEP;
                        src_n = SRC_NONE;
                    end else if (settle_done) begin
                        st_n  = ST_ACTIVE;
                        src_n = SRC_NONE;
                        if (src_q == SRC_WDOG) begin
                            core_rst_n = 1'b1;
                        end else begin
                            load     = 1'b1;
                            load_src = src_q;
                        end
                    end
                end
                default: st_n = ST_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_ACTIVE;
            mode_q     <= MODE_IDLE;
            src_q      <= SRC_NONE;
            core_rst_q <= 1'b0;
        end else begin
            st         <= st_n;
            mode_q     <= mode_n;
            src_q      <= src_n;
            core_rst_q <= core_rst_n;
        end
    end

    slp_flag_delay #(.EXT_LAT(EXT_LAT), .TMR_LAT(TMR_LAT)) u_flag (
        .clk        (clk),
        .rst        (rst),
        .clr        (ext_rst),
        .load       (load),
        .load_src   (load_src),
        .active     (st == ST_ACTIVE),
        .instr_tick (instr_tick),
        .gie        (gie),
        .flag_upd   (flag_upd),
        .isr_go     (isr_go)
    );

    assign core_clk_en  = (st == ST_ACTIVE);
    assign osc_en       = (st != ST_DEEP);
    assign wake_pending = (st == ST_SETTLE);
    assign core_rst     = core_rst_q;

    // R3: reserved mode code leaves the core running
    assert_rsvd_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (core_clk_en && sleep_req && sleep_mode == 2'b01 && !ext_rst) |=> core_clk_en);

    // R11: external reset always restores the running state
    assert_extrst_wakes_R11: assert property (@(posedge clk) disable iff (rst)
        ext_rst |=> (core_clk_en && !wake_pending && !flag_upd));

    // R7: the core clock never returns directly from a stopped oscillator
    assert_deep_via_settle_R7: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !ext_rst) |=> !core_clk_en);

    // R8: losing the level during stabilisation drops back to sleep
    assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        (wake_pending && src_q == SRC_LEVEL && !lvl_irq && !ext_rst) |=> !osc_en);

endmodule

// File: tb/slp_ctrl_tb.sv
module slp_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TOUT       = 4;

    logic clk = 1'b0;
    logic rst, ext_rst, wdt_rst, wdt_en, sleep_req, lvl_irq, tmr_async;
    logic tmr_ovf, tmr_ovf_ie, tmr_cmp, tmr_cmp_ie, gie, settle_tick, instr_tick;
    logic [1:0] sleep_mode;
    logic core_clk_en, osc_en, wake_pending, flag_upd, isr_go, core_rst;

    int vec_cnt  = 0;
    int miss_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    slp_ctrl #(.TOUT_TICKS(TOUT)) dut_i (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .wdt_rst(wdt_rst), .wdt_en(wdt_en),
        .sleep_req(sleep_req), .sleep_mode(sleep_mode), .lvl_irq(lvl_irq),
        .tmr_async(tmr_async), .tmr_ovf(tmr_ovf), .tmr_ovf_ie(tmr_ovf_ie),
        .tmr_cmp(tmr_cmp), .tmr_cmp_ie(tmr_cmp_ie), .gie(gie),
        .settle_tick(settle_tick), .instr_tick(instr_tick),
        .core_clk_en(core_clk_en), .osc_en(osc_en), .wake_pending(wake_pending),
        .flag_upd(flag_upd), .isr_go(isr_go), .core_rst(core_rst)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        vec_cnt++;
        if (act !== exp) begin
            miss_cnt++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        ext_rst = 0; wdt_rst = 0; wdt_en = 0; sleep_req = 0; sleep_mode = 2'b00;
        lvl_irq = 0; tmr_async = 0; tmr_ovf = 0; tmr_ovf_ie = 0; tmr_cmp = 0;
        tmr_cmp_ie = 0; gie = 0; settle_tick = 0; instr_tick = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst = 1;
        step();
        step();
        rst = 0;
    endtask

    task automatic go_sleep(input logic [1:0] m);
        sleep_mode = m;
        sleep_req  = 1;
        step();
        sleep_req  = 0;
    endtask

    task automatic pulse_ext_rst();
        ext_rst = 1;
        step();
        ext_rst = 0;
    endtask

    // flag strobe must appear on the lat-th instruction tick (R9, R10)
    task automatic flag_window(input int lat, input logic g);
        for (int k = 1; k <= lat; k++) begin
            instr_tick = 1;
            step();
            instr_tick = 0;
            if (k < lat) begin
                chk("R9 early flag", flag_upd, 1'b0);
            end else begin
                chk("R9 flag on last tick", flag_upd, 1'b1);
                chk("R10 isr follows gie", isr_go, g);
            end
            step();
            chk("R9 flag single cycle", flag_upd, 1'b0);
        end
    endtask

    task automatic no_flag(input string tag, input int n);
        for (int k = 0; k < n; k++) begin
            instr_tick = 1;
            step();
            instr_tick = 0;
            chk(tag, flag_upd, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miss_cnt++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 core_clk_en", core_clk_en, 1'b1);
        chk("R1 osc_en", osc_en, 1'b1);
        chk("R1 wake_pending", wake_pending, 1'b0);
        chk("R1 flag_upd", flag_upd, 1'b0);
        chk("R1 isr_go", isr_go, 1'b0);
        chk("R1 core_rst", core_rst, 1'b0);

        // R2, R3: every mode code; leave with R11 external reset
        for (int m = 0; m < 4; m++) begin
            do_reset();
            go_sleep(2'(m));
            chk(m == 1 ? "R3 reserved ignored" : "R2 core clock gated",
                core_clk_en, (m == 1));
            chk("R2 oscillator", osc_en, (m < 2));
            step();
            chk(m == 1 ? "R3 still running" : "R2 still asleep", core_clk_en, (m == 1));
            pulse_ext_rst();
            chk("R11 ext reset restores clock", core_clk_en, 1'b1);
            chk("R11 ext reset oscillator", osc_en, 1'b1);
        end

        // R4, R9, R10: idle wake sweep over sources, enables and gie
        for (int s = 0; s < 3; s++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int g = 0; g < 2; g++) begin
                    logic woke;
                    do_reset();
                    gie = g[0];
                    tmr_ovf_ie = ie[0];
                    tmr_cmp_ie = ie[0];
                    go_sleep(2'b00);
                    if (s == 0) lvl_irq = 1;
                    if (s == 1) tmr_ovf = 1;
                    if (s == 2) tmr_cmp = 1;
                    step();
                    lvl_irq = 0; tmr_ovf = 0; tmr_cmp = 0;
                    woke = (s == 0) || (ie == 1);
                    chk("R4 idle wake immediate", core_clk_en, woke);
                    chk("R4 no stabilisation in idle", wake_pending, 1'b0);
                    if (woke) begin
                        flag_window((s == 0) ? 2 : 3, g[0]);
                    end else begin
                        step();
                        chk("R4 disabled timer keeps idle", core_clk_en, 1'b0);
                    end
                end
            end
        end

        // R5, R6, R7, R9, R12: deep-state source sweep
        // s: 0 level, 1 overflow, 2 compare, 3 watchdog enabled, 4 watchdog disabled
        for (int m = 2; m < 4; m++) begin
            for (int a = 0; a < 2; a++) begin
                for (int s = 0; s < 5; s++) begin
                    logic woke;
                    do_reset();
                    tmr_async = a[0];
                    tmr_ovf_ie = 1;
                    tmr_cmp_ie = 1;
                    wdt_en = (s == 3);
                    gie = 0;
                    go_sleep(2'(m));
                    chk("R2 deep oscillator off", osc_en, 1'b0);
                    if (s == 0) lvl_irq = 1;
                    if (s == 1) tmr_ovf = 1;
                    if (s == 2) tmr_cmp = 1;
                    if (s >= 3) wdt_rst = 1;
                    step();
                    tmr_ovf = 0; tmr_cmp = 0; wdt_rst = 0;
                    woke = (s == 0) || (s == 3) || (m == 3 && a == 1 && (s == 1 || s == 2));
                    chk(m == 3 ? "R6 power-save wake set" : "R5 power-down wake set",
                        wake_pending, woke);
                    chk("R7 oscillator on during settle", osc_en, woke);
                    chk("R7 core gated at wake", core_clk_en, 1'b0);
                    if (woke) begin
                        for (int t = 1; t <= TOUT; t++) begin
                            settle_tick = 1;
                            step();
                            settle_tick = 0;
                            chk("R7 release on last tick", core_clk_en, (t == TOUT));
                            if (t == TOUT) begin
                                chk("R12 watchdog core reset", core_rst, (s == 3));
                            end else begin
                                chk("R7 pending while settling", wake_pending, 1'b1);
                                step();
                            end
                        end
                        lvl_irq = 0;
                        if (s == 3) no_flag("R12 no flag after watchdog", 5);
                        else flag_window((s == 0) ? 2 : 3, 1'b0);
                    end else begin
                        for (int t = 0; t < TOUT + 2; t++) begin
                            settle_tick = 1;
                            step();
                            settle_tick = 0;
                        end
                        chk("R5 stays asleep", osc_en, 1'b0);
                        pulse_ext_rst();
                        chk("R11 ext reset from deep", core_clk_en, 1'b1);
                    end
                end
            end
        end

        // R8: level dropped during stabilisation cancels the wake
        do_reset();
        go_sleep(2'b10);
        lvl_irq = 1;
        step();
        chk("R8 settle entered", wake_pending, 1'b1);
        settle_tick = 1; step(); settle_tick = 0;
        settle_tick = 1; step(); settle_tick = 0;
        lvl_irq = 0;
        step();
        chk("R8 back to deep osc", osc_en, 1'b0);
        chk("R8 pending cleared", wake_pending, 1'b0);
        for (int t = 0; t < TOUT + 2; t++) begin
            settle_tick = 1;
            step();
            settle_tick = 0;
        end
        chk("R8 remains asleep", core_clk_en, 1'b0);
        no_flag("R8 no flag after cancel", 4);

        // R11: external reset during stabilisation and during the flag window
        do_reset();
        go_sleep(2'b11);
        lvl_irq = 1;
        step();
        pulse_ext_rst();
        chk("R11 ext reset during settle", core_clk_en, 1'b1);
        chk("R11 settle abandoned", wake_pending, 1'b0);
        lvl_irq = 0;
        go_sleep(2'b00);
        lvl_irq = 1;
        step();
        lvl_irq = 0;
        instr_tick = 1; step(); instr_tick = 0;
        pulse_ext_rst();
        no_flag("R11 pending flag cancelled", 4);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

endmodule